// File: doc/BRIEF.md
# Reloadable Periodic Interrupt Timer

This block is a down-counting periodic timer that advances on a 32768 Hz tick-enable. It is synchronous to the bus clock. Software writes a reload value, which is the tick rate divided by the wanted interrupt rate, and then sets a run bit. The counter starts from that value and counts one step on each tick. On the tick that finds the counter at its last step, the block raises a periodic event and reloads the counter, so events occur every reload-value ticks. While the timer runs, the reload value is locked. A self-start option lets a single reload write both store the value and start the counter.

The periodic event has bit 1 of a two-bit interrupt group: a mask, a raw status, a masked status and a write-one-to-clear register. Bit 0 of the same group belongs to a neighbouring alarm, which reaches this block as a one-cycle event input. All registers are reached through an APB-style slave port that completes every transfer in its access phase. The interrupt line is the OR of the masked status bits.

Top module: `rpt_timer`

## Requirements
- R1: After reset every register reads 0, the timer is stopped and `irq_o` is low.
- R2: Register offsets are 0x10 mask, 0x14 raw status, 0x18 masked status, 0x1C clear (write-only, reads 0), 0x20 current count, 0x24 reload value, 0x28 control. A reload write while stopped stores the low CNT_W bits, and they read back at 0x24 zero-extended.
- R3: In the control register, bit 1 is run and bit 0 is self-start. A control write that changes run from 0 to 1 copies the reload value into the current count.
- R4: Each tick while running lowers the count by one. A tick that finds the count at 1 sets raw bit 1 and restores the reload value, so events come every reload-value ticks.
- R5: A reload write while the timer runs is ignored, and the reload value is unchanged.
- R6: Clearing run freezes the current count, and no periodic event is raised while the timer is stopped.
- R7: A reload value of 0 behaves as 1, giving an event on every tick.
- R8: With self-start set and the timer stopped, a reload write stores the value, sets run and loads the count from the new value.
- R9: Masked status is raw AND mask, bit by bit. Raw bits set regardless of the mask. `irq_o` is high exactly when any masked bit is set.
- R10: Writing 1 to a bit of the clear register clears that raw bit, and writing 0 leaves it alone. An event in the same cycle wins over the clear. `alarm_evt_i` sets raw bit 0.
- R11: A control write in the same cycle as a tick takes precedence over the tick. Writing run=1 while already running does not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32768 Hz tick enable, one cycle wide |
| alarm_evt_i | input | 1 | One-cycle alarm event, sets raw bit 0 |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 write, 0 read |
| paddr_i | input | ADDR_W | Byte address |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data, valid while selected for a read |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A wrong count or a lost reload does not show at once. It appears as a periodic event on the wrong tick, which the interrupt line reveals within one reload period, or as a wrong value read at the current-count offset. A reload value that was wrongly overwritten while running only becomes visible after the next expiry, when the period changes, so the bench also reads the reload register directly. Per-clock comparison of `irq_o` against a behavioural model catches a stray or missing raw set, or a failed clear, in the cycle after the event.

// File: rtl/rpt_pkg.sv
package rpt_pkg;

    // Register byte offsets; software decodes these
    localparam logic [7:0] OFS_MASK = 8'h10;
    localparam logic [7:0] OFS_RAW  = 8'h14;
    localparam logic [7:0] OFS_MIS  = 8'h18;
    localparam logic [7:0] OFS_CLR  = 8'h1C;
    localparam logic [7:0] OFS_CUR  = 8'h20;
    localparam logic [7:0] OFS_LOAD = 8'h24;
    localparam logic [7:0] OFS_CTRL = 8'h28;

    // Control bit positions
    localparam int CTRL_SELF = 0;
    localparam int CTRL_RUN  = 1;

    // Interrupt group bit positions
    localparam int IRQ_ALARM  = 0;
    localparam int IRQ_PERIOD = 1;
    localparam int NUM_IRQ    = 2;

    typedef struct packed {
        logic mask_wr;
        logic clr_wr;
        logic load_wr;
        logic ctrl_wr;
    } wr_strobe_t;

endpackage

// File: rtl/rpt_regif.sv
module rpt_regif
    import rpt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                psel_i,
    input  logic                penable_i,
    input  logic                pwrite_i,
    input  logic [ADDR_W-1:0]   paddr_i,
    input  logic [CNT_W-1:0]    cur_i,
    input  logic [CNT_W-1:0]    load_i,
    input  logic                run_i,
    input  logic                self_i,
    input  logic [NUM_IRQ-1:0]  raw_i,
    input  logic [NUM_IRQ-1:0]  mask_i,
    input  logic [NUM_IRQ-1:0]  mis_i,
    output wr_strobe_t          strb_o,
    output logic [DATA_W-1:0]   prdata_o
);

    logic wr_access;
    logic rd_sel;

    assign wr_access = psel_i && penable_i && pwrite_i;
    assign rd_sel    = psel_i && !pwrite_i;

    always_comb begin
        strb_o         = '0;
        strb_o.mask_wr = wr_access && (paddr_i == ADDR_W'(OFS_MASK));
        strb_o.clr_wr  = wr_access && (paddr_i == ADDR_W'(OFS_CLR));
        strb_o.load_wr = wr_access && (paddr_i == ADDR_W'(OFS_LOAD));
        strb_o.ctrl_wr = wr_access && (paddr_i == ADDR_W'(OFS_CTRL));
    end

    always_comb begin
        prdata_o = '0;
        if (rd_sel) begin
            if (paddr_i == ADDR_W'(OFS_MASK)) begin
                prdata_o = DATA_W'(mask_i);
            end else if (paddr_i == ADDR_W'(OFS_RAW)) begin
                prdata_o = DATA_W'(raw_i);
            end else if (paddr_i == ADDR_W'(OFS_MIS)) begin
                prdata_o = DATA_W'(mis_i);
            end else if (paddr_i == ADDR_W'(OFS_CUR)) begin
                prdata_o = DATA_W'(cur_i);
            end else if (paddr_i == ADDR_W'(OFS_LOAD)) begin
                prdata_o = DATA_W'(load_i);
            end else if (paddr_i == ADDR_W'(OFS_CTRL)) begin
                prdata_o[CTRL_RUN]  = run_i;
                prdata_o[CTRL_SELF] = self_i;
            end
        end
    end

endmodule

// File: rtl/rpt_counter.sv
module rpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ctrl_wr_i,
    input  logic             ctrl_run_i,
    input  logic             ctrl_self_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             run_o,
    output logic             self_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic             self_start;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    function automatic logic [CNT_W-1:0] eff_load(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (ctrl_wr_i) begin
            st_d.self_start = ctrl_self_i;
            st_d.run        = ctrl_run_i;
            if (ctrl_run_i && !st_q.run) begin
                st_d.cnt = eff_load(st_q.load);
            end
        end else if (load_wr_i && !st_q.run) begin
            st_d.load = load_val_i;
            if (st_q.self_start) begin
                st_d.run = 1'b1;
                st_d.cnt = eff_load(load_val_i);
            end
        end else if (st_q.run && tick_i) begin
            if (st_q.cnt <= ONE) begin
                expire_o = 1'b1;
                st_d.cnt = eff_load(st_q.load);
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o  = st_q.run;
    assign self_o = st_q.self_start;
    assign load_o = st_q.load;
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/rpt_irq.sv
module rpt_irq #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic               clr_wr_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] mask_bits_i,
    output logic [NUM_SRC-1:0] raw_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] mis_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] raw;
        logic [NUM_SRC-1:0] mask;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            // a set in the same cycle as a clear wins
            if (set_i[i]) begin
                st_d.raw[i] = 1'b1;
            end else if (clr_wr_i && clr_bits_i[i]) begin
                st_d.raw[i] = 1'b0;
            end
        end
        if (mask_wr_i) begin
            st_d.mask = mask_bits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_mis
            assign mis_o[g] = st_q.raw[g] & st_q.mask[g];
        end
    endgenerate

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign irq_o  = |mis_o;

endmodule

// File: rtl/rpt_timer.sv
module rpt_timer
    import rpt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              alarm_evt_i,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [DATA_W-1:0] pwdata_i,
    output logic [DATA_W-1:0] prdata_o,
    output logic              irq_o
);

    wr_strobe_t         strb;
    logic               tmr_run;
    logic               tmr_self;
    logic [CNT_W-1:0]   tmr_load;
    logic [CNT_W-1:0]   tmr_cnt;
    logic               tmr_expire;
    logic [NUM_IRQ-1:0] irq_set;
    logic [NUM_IRQ-1:0] irq_raw;
    logic [NUM_IRQ-1:0] irq_mask;
    logic [NUM_IRQ-1:0] irq_mis;

    rpt_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regif (
        .psel_i    (psel_i),
        .penable_i (penable_i),
        .pwrite_i  (pwrite_i),
        .paddr_i   (paddr_i),
        .cur_i     (tmr_cnt),
        .load_i    (tmr_load),
        .run_i     (tmr_run),
        .self_i    (tmr_self),
        .raw_i     (irq_raw),
        .mask_i    (irq_mask),
        .mis_i     (irq_mis),
        .strb_o    (strb),
        .prdata_o  (prdata_o)
    );

    rpt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .ctrl_wr_i   (strb.ctrl_wr),
        .ctrl_run_i  (pwdata_i[CTRL_RUN]),
        .ctrl_self_i (pwdata_i[CTRL_SELF]),
        .load_wr_i   (strb.load_wr),
        .load_val_i  (pwdata_i[CNT_W-1:0]),
        .run_o       (tmr_run),
        .self_o      (tmr_self),
        .load_o      (tmr_load),
        .cnt_o       (tmr_cnt),
        .expire_o    (tmr_expire)
    );

    always_comb begin
        irq_set             = '0;
        irq_set[IRQ_ALARM]  = alarm_evt_i;
        irq_set[IRQ_PERIOD] = tmr_expire;
    end

    rpt_irq #(
        .NUM_SRC (NUM_IRQ)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (irq_set),
        .clr_wr_i    (strb.clr_wr),
        .clr_bits_i  (pwdata_i[NUM_IRQ-1:0]),
        .mask_wr_i   (strb.mask_wr),
        .mask_bits_i (pwdata_i[NUM_IRQ-1:0]),
        .raw_o       (irq_raw),
        .mask_o      (irq_mask),
        .mis_o       (irq_mis),
        .irq_o       (irq_o)
    );

endmodule

// File: rtl/rpt_timer_chk.sv
module rpt_timer_chk
    import rpt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               psel_i,
    input logic               penable_i,
    input logic               pwrite_i,
    input logic [ADDR_W-1:0]  paddr_i,
    input logic [DATA_W-1:0]  pwdata_i,
    input logic               irq_o,
    input logic               tmr_run,
    input logic [CNT_W-1:0]   tmr_load,
    input logic [CNT_W-1:0]   tmr_cnt,
    input logic [NUM_IRQ-1:0] irq_raw
);

    logic c_ctrl_wr, c_load_wr, c_clr_wr;
    logic [CNT_W-1:0] c_eff;

    assign c_ctrl_wr = psel_i && penable_i && pwrite_i && (paddr_i == ADDR_W'(OFS_CTRL));
    assign c_load_wr = psel_i && penable_i && pwrite_i && (paddr_i == ADDR_W'(OFS_LOAD));
    assign c_clr_wr  = psel_i && penable_i && pwrite_i && (paddr_i == ADDR_W'(OFS_CLR));
    assign c_eff     = (tmr_load == '0) ? CNT_W'(1) : tmr_load;

    p_reload_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_run) |-> (tmr_cnt == c_eff));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |-> (tmr_cnt != '0 && tmr_cnt <= c_eff));

    p_load_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && c_load_wr) |=> $stable(tmr_load));

    p_frozen_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_run && !c_ctrl_wr && !c_load_wr) |=> ($stable(tmr_cnt) && !$rose(irq_raw[IRQ_PERIOD])));

    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_raw != '0));

    p_raw_fall_by_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_raw[IRQ_PERIOD]) |-> $past(c_clr_wr && pwdata_i[IRQ_PERIOD]));

endmodule

bind rpt_timer rpt_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .irq_o     (irq_o),
    .tmr_run   (tmr_run),
    .tmr_load  (tmr_load),
    .tmr_cnt   (tmr_cnt),
    .irq_raw   (irq_raw)
);

// File: tb/tb_rpt_timer.sv
module tb_rpt_timer;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic              alarm_evt_i = 1'b0;
    logic              psel_i = 1'b0;
    logic              penable_i = 1'b0;
    logic              pwrite_i = 1'b0;
    logic [ADDR_W-1:0] paddr_i = '0;
    logic [DATA_W-1:0] pwdata_i = '0;
    logic [DATA_W-1:0] prdata_o;
    logic              irq_o;

    int checks = 0;
    int errors = 0;
    int tick_div = 0;
    int tick_cnt = 0;
    bit finished = 0;

    // behavioural reference state
    int m_cnt = 0, m_load = 0, m_en = 0, m_ss = 0, m_raw = 0, m_mask = 0;

    rpt_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .alarm_evt_i(alarm_evt_i),
        .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
        .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_en = 0; m_ss = 0; m_raw = 0; m_mask = 0;
        end else begin
            bit wr;
            bit ev;
            wr = psel_i && penable_i && pwrite_i;
            ev = 0;
            if (wr && paddr_i == 8'h28) begin
                m_ss = int'(pwdata_i[0]);
                if (pwdata_i[1] && m_en == 0) m_cnt = eff(m_load);
                m_en = int'(pwdata_i[1]);
            end else if (wr && paddr_i == 8'h24 && m_en == 0) begin
                m_load = int'(pwdata_i[15:0]);
                if (m_ss != 0) begin
                    m_en = 1;
                    m_cnt = eff(m_load);
                end
            end else if (m_en != 0 && tick_i) begin
                if (m_cnt <= 1) begin
                    ev = 1;
                    m_cnt = eff(m_load);
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (wr && paddr_i == 8'h1C) m_raw = m_raw & ~int'(pwdata_i[1:0]);
            if (alarm_evt_i) m_raw = m_raw | 1;
            if (ev) m_raw = m_raw | 2;
            if (wr && paddr_i == 8'h10) m_mask = int'(pwdata_i[1:0]);
        end
    end

    function automatic int model_reg(input logic [7:0] a);
        case (a)
            8'h10: return m_mask;
            8'h14: return m_raw;
            8'h18: return m_raw & m_mask;
            8'h20: return m_cnt;
            8'h24: return m_load;
            8'h28: return (m_en << 1) | m_ss;
            default: return 0;
        endcase
    endfunction

    // tick generator
    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick_i = 1'b0;
        end else begin
            tick_cnt = tick_cnt + 1;
            tick_i = (tick_cnt % tick_div) == 0;
        end
    end

    // interrupt line compared every clock (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq_o !== ((m_raw & m_mask) != 0)) begin
                errors++;
                $display("FAIL R9 irq_o actual %0b expected %0b at %0t",
                         irq_o, (m_raw & m_mask) != 0, $time);
            end
        end
    end

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input int d);
        @(negedge clk);
        psel_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = DATA_W'(d); penable_i = 1'b0;
        @(negedge clk);
        penable_i = 1'b1;
        @(negedge clk);
        psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input string tag);
        int exp;
        @(negedge clk);
        psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = a; penable_i = 1'b0;
        @(negedge clk);
        penable_i = 1'b1;
        #1;
        exp = model_reg(a);
        check_val(tag, int'(prdata_o), exp);
        @(negedge clk);
        psel_i = 1'b0; penable_i = 1'b0;
    endtask

    task automatic read_lit(input logic [7:0] a, input int exp, input string tag);
        @(negedge clk);
        psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = a; penable_i = 1'b0;
        @(negedge clk);
        penable_i = 1'b1;
        #1;
        check_val(tag, int'(prdata_o), exp);
        @(negedge clk);
        psel_i = 1'b0; penable_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        read_lit(8'h10, 0, "R1 mask");
        read_lit(8'h14, 0, "R1 raw");
        read_lit(8'h18, 0, "R1 masked");
        read_lit(8'h20, 0, "R1 count");
        read_lit(8'h24, 0, "R1 reload");
        read_lit(8'h28, 0, "R1 ctrl");
        read_lit(8'h1C, 0, "R2 clear reads zero");

        // R2 reload store, upper bits dropped
        bus_write(8'h10, 2);
        bus_write(8'h24, 32'h0003_0005);
        read_lit(8'h24, 5, "R2 reload readback");

        // R3 start copies reload
        bus_write(8'h28, 2);
        read_lit(8'h20, 5, "R3 count after start");
        read_lit(8'h28, 2, "R3 ctrl run");

        // R4 counting with ticks every cycle
        tick_div = 1;
        for (int i = 0; i < 6; i++) begin
            bus_read(8'h20, "R4 count");
        end
        bus_read(8'h14, "R4 raw after expiry");
        bus_read(8'h18, "R9 masked");

        // R5 reload write while running is ignored
        bus_write(8'h24, 9);
        read_lit(8'h24, 5, "R5 reload locked");

        // R10 clear
        tick_div = 0;
        bus_write(8'h1C, 2);
        bus_read(8'h14, "R10 raw after clear");
        bus_write(8'h1C, 0);
        bus_read(8'h14, "R10 zero clear no effect");

        // R6 freeze
        tick_div = 3;
        idle(5);
        bus_write(8'h28, 0);
        bus_write(8'h1C, 3);
        bus_read(8'h20, "R6 frozen count a");
        idle(40);
        bus_read(8'h20, "R6 frozen count b");
        read_lit(8'h14, 0, "R6 no event while stopped");
        bus_write(8'h28, 2);
        read_lit(8'h20, 5, "R3 restart reloads");
        idle(30);
        bus_read(8'h14, "R4 raw slow ticks");
        bus_read(8'h20, "R4 count slow ticks");

        // R7 reload 0 acts as 1
        bus_write(8'h28, 0);
        bus_write(8'h1C, 3);
        bus_write(8'h24, 0);
        bus_write(8'h28, 2);
        read_lit(8'h20, 1, "R7 count from zero reload");
        tick_div = 1;
        idle(4);
        bus_write(8'h1C, 2);
        read_lit(8'h14, 2, "R10 set wins over clear");
        bus_read(8'h20, "R7 count stays one");

        // R8 self-start
        tick_div = 0;
        bus_write(8'h28, 1);
        bus_write(8'h1C, 3);
        read_lit(8'h28, 1, "R8 ctrl self only");
        bus_write(8'h24, 7);
        read_lit(8'h28, 3, "R8 run set by reload");
        read_lit(8'h20, 7, "R8 count loaded");

        // R11 run rewrite does not reload; ctrl write beats tick
        tick_div = 1;
        idle(3);
        bus_write(8'h28, 3);
        bus_read(8'h20, "R11 no reload on rewrite");
        idle(9);
        bus_read(8'h14, "R11 raw");

        // R10 alarm event, R9 mask
        tick_div = 0;
        bus_write(8'h28, 0);
        bus_write(8'h1C, 3);
        bus_write(8'h10, 1);
        @(negedge clk);
        alarm_evt_i = 1'b1;
        @(negedge clk);
        alarm_evt_i = 1'b0;
        read_lit(8'h14, 1, "R10 alarm sets bit 0");
        read_lit(8'h18, 1, "R9 masked alarm");
        bus_write(8'h10, 2);
        read_lit(8'h18, 0, "R9 alarm masked off");
        bus_write(8'h1C, 1);
        read_lit(8'h14, 0, "R10 alarm cleared");
        idle(4);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule